// File: doc/BRIEF.md
# Immediate-Operand Merge and Masked-Subtract Unit

This block is the execution stage for three rarely used immediate-mode opcodes of an 8-bit accumulator processor. The sequencer presents an opcode, the current accumulator (A) and index (X) registers, the immediate byte and the status flags (carry, decimal, negative, zero, overflow), together with a one-cycle start strobe. On the next clock the unit returns the new A, the new X and the new flags, raises a one-cycle completion pulse, and reports whether the opcode was one it knows.

Two opcodes merge the registers through a fixed OR constant, which on real silicon is unstable and is therefore a parameter here. Opcode 8'h8B writes the merged value into A only. Opcode 8'hAB writes one value into both A and X. A second parameter selects a simpler form of 8'hAB that skips the OR constant and X. The third opcode, 8'hCB, reuses compare hardware. It subtracts the immediate from A AND X, always in binary and with no borrow-in, writes the difference into X and sets carry as a compare would.

Top module: `imm_op_unit`

## Requirements
- R1: While reset is asserted and after it is released with no start, a_out, x_out, c_out, n_out, z_out, v_out, done and illegal are all 0.
- R2: done is high in exactly the cycle after a cycle with start high, and low otherwise. In cycles not preceded by a start, all result outputs hold their previous values.
- R3: Opcode 8'h8B gives a_out = (a_in | MAGIC) & x_in & imm, with MAGIC defaulting to 8'hEE, and x_out = x_in.
- R4: Opcode 8'hAB with the default variant (PLAIN_LOAD = 0) gives a_out = x_out = (a_in | MAGIC) & x_in & imm.
- R5: For 8'h8B and 8'hAB, n_out is bit 7 of the new A and z_out is 1 exactly when the new A is zero. c_out and v_out equal c_in and v_in.
- R6: Opcode 8'hCB gives x_out = ((a_in & x_in) - imm) mod 256 and a_out = a_in. d_in and c_in do not affect any result.
- R7: For 8'hCB, c_out is 1 exactly when (a_in & x_in) >= imm as unsigned numbers.
- R8: For 8'hCB, n_out is bit 7 of the new X, z_out is 1 exactly when the new X is zero, and v_out equals v_in.
- R9: Any other opcode (including 8'hEB) raises illegal together with done, and every result output equals the corresponding input. illegal is 0 for the three known opcodes and whenever done is low.
- R10: With PLAIN_LOAD = 1, opcode 8'hAB gives a_out = x_out = a_in & imm, with flags as in R5. The other opcodes behave as in R3 and R6 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation strobe for one cycle |
| opcode | input | 8 | Opcode to execute |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| imm | input | 8 | Immediate operand |
| c_in | input | 1 | Current carry flag |
| d_in | input | 1 | Current decimal flag (never used) |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| v_in | input | 1 | Current overflow flag |
| a_out | output | 8 | New accumulator |
| x_out | output | 8 | New index register |
| c_out | output | 1 | New carry flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| v_out | output | 1 | New overflow flag |
| done | output | 1 | Result valid, one-cycle pulse |
| illegal | output | 1 | Opcode not handled, valid with done |

## Verification
The assertions check on every cycle the timing of the done pulse and the holding of results between operations. They also check that illegal never appears without done, that overflow is always carried through, that the subtract opcode keeps A and sets carry by unsigned comparison, that the dual load writes equal A and X, and that the zero flag tracks the new A for the merge opcodes. Only the bench scenarios show the exact merged and subtracted values, that decimal mode and carry-in have no effect, the pass-through on unknown opcodes, and the plain load variant. The bench compares a second instance built with that variant against its own reference model.

// File: rtl/imm_op_pkg.sv
package imm_op_pkg;

  localparam int WORD_W = 8;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] CODE_MERGE = 8'h8B;
  localparam logic [CODE_W-1:0] CODE_LOAD  = 8'hAB;
  localparam logic [CODE_W-1:0] CODE_SUB   = 8'hCB;

  typedef enum logic [1:0] {
    KIND_MERGE = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_SUB   = 2'd2,
    KIND_NONE  = 2'd3
  } op_kind_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
    logic v;
  } flags_t;

  // Wired-AND merge of both registers and the operand through the OR constant.
  function automatic logic [WORD_W-1:0] merge_value(
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] x,
    input logic [WORD_W-1:0] operand,
    input logic [WORD_W-1:0] magic
  );
    return (a | magic) & x & operand;
  endfunction

  // Plain load form: accumulator masked by the operand only.
  function automatic logic [WORD_W-1:0] plain_value(
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] operand
  );
    return a & operand;
  endfunction

  // Compare-style subtraction: bit WORD_W is the no-borrow carry.
  function automatic logic [WORD_W:0] masked_sub(
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] x,
    input logic [WORD_W-1:0] operand
  );
    logic [WORD_W:0] lhs;
    logic [WORD_W:0] rhs;
    lhs = {1'b0, a & x};
    rhs = {1'b0, ~operand};
    return lhs + rhs + {{WORD_W{1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/imm_op_decode.sv
module imm_op_decode
  import imm_op_pkg::*;
(
  input  logic [CODE_W-1:0] opcode,
  output op_kind_e          kind,
  output logic              bad_code
);

  always_comb begin
    unique case (opcode)
      CODE_MERGE: kind = KIND_MERGE;
      CODE_LOAD:  kind = KIND_LOAD;
      CODE_SUB:   kind = KIND_SUB;
      default:    kind = KIND_NONE;
    endcase
  end

  assign bad_code = (kind == KIND_NONE);

endmodule

// File: rtl/imm_op_merge.sv
module imm_op_merge
  import imm_op_pkg::*;
#(
  parameter logic [WORD_W-1:0] MAGIC      = 8'hEE,
  parameter bit                PLAIN_LOAD = 1'b0
)(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] merge_res,
  output logic [WORD_W-1:0] load_res
);

  assign merge_res = merge_value(a, x, operand, MAGIC);

  generate
    if (PLAIN_LOAD) begin : g_plain
      assign load_res = plain_value(a, operand);
    end else begin : g_magic
      assign load_res = merge_value(a, x, operand, MAGIC);
    end
  endgenerate

endmodule

// File: rtl/imm_op_sub.sv
module imm_op_sub
  import imm_op_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] diff,
  output logic              no_borrow
);

  logic [WORD_W:0] raw;

  assign raw       = masked_sub(a, x, operand);
  assign diff      = raw[WORD_W-1:0];
  assign no_borrow = raw[WORD_W];

endmodule

// File: rtl/imm_op_unit.sv
module imm_op_unit
  import imm_op_pkg::*;
#(
  parameter logic [WORD_W-1:0] MAGIC      = 8'hEE,
  parameter bit                PLAIN_LOAD = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] opcode,
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] x_in,
  input  logic [WORD_W-1:0] imm,
  input  logic              c_in,
  input  logic              d_in,
  input  logic              n_in,
  input  logic              z_in,
  input  logic              v_in,
  output logic [WORD_W-1:0] a_out,
  output logic [WORD_W-1:0] x_out,
  output logic              c_out,
  output logic              n_out,
  output logic              z_out,
  output logic              v_out,
  output logic              done,
  output logic              illegal
);

  op_kind_e          kind;
  logic              bad_code;
  logic [WORD_W-1:0] merge_res;
  logic [WORD_W-1:0] load_res;
  logic [WORD_W-1:0] sub_diff;
  logic              sub_carry;

  // Named events for the checker.
  logic op_merge;
  logic op_load;
  logic op_sub;

  // The decimal flag plays no part in any of these opcodes.
  logic unused_decimal;
  assign unused_decimal = d_in;

  imm_op_decode u_dec (
    .opcode   (opcode),
    .kind     (kind),
    .bad_code (bad_code)
  );

  imm_op_merge #(
    .MAGIC      (MAGIC),
    .PLAIN_LOAD (PLAIN_LOAD)
  ) u_merge (
    .a         (a_in),
    .x         (x_in),
    .operand   (imm),
    .merge_res (merge_res),
    .load_res  (load_res)
  );

  imm_op_sub u_sub (
    .a         (a_in),
    .x         (x_in),
    .operand   (imm),
    .diff      (sub_diff),
    .no_borrow (sub_carry)
  );

  assign op_merge = (kind == KIND_MERGE);
  assign op_load  = (kind == KIND_LOAD);
  assign op_sub   = (kind == KIND_SUB);

  logic [WORD_W-1:0] a_nxt;
  logic [WORD_W-1:0] x_nxt;
  flags_t            f_nxt;

  always_comb begin
    a_nxt = a_in;
    x_nxt = x_in;
    f_nxt = '{c: c_in, n: n_in, z: z_in, v: v_in};
    unique case (kind)
      KIND_MERGE: begin
        a_nxt   = merge_res;
        f_nxt.n = merge_res[WORD_W-1];
        f_nxt.z = (merge_res == '0);
      end
      KIND_LOAD: begin
        a_nxt   = load_res;
        x_nxt   = load_res;
        f_nxt.n = load_res[WORD_W-1];
        f_nxt.z = (load_res == '0);
      end
      KIND_SUB: begin
        x_nxt   = sub_diff;
        f_nxt.c = sub_carry;
        f_nxt.n = sub_diff[WORD_W-1];
        f_nxt.z = (sub_diff == '0);
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out   <= '0;
      x_out   <= '0;
      c_out   <= 1'b0;
      n_out   <= 1'b0;
      z_out   <= 1'b0;
      v_out   <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= start;
      illegal <= start & bad_code;
      if (start) begin
        a_out <= a_nxt;
        x_out <= x_nxt;
        c_out <= f_nxt.c;
        n_out <= f_nxt.n;
        z_out <= f_nxt.z;
        v_out <= f_nxt.v;
      end
    end
  end

endmodule

// File: rtl/imm_op_unit_chk.sv
module imm_op_unit_chk
  import imm_op_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WORD_W-1:0] a_in,
  input logic [WORD_W-1:0] x_in,
  input logic [WORD_W-1:0] imm,
  input logic              v_in,
  input logic              op_merge,
  input logic              op_load,
  input logic              op_sub,
  input logic [WORD_W-1:0] a_out,
  input logic [WORD_W-1:0] x_out,
  input logic              c_out,
  input logic              n_out,
  input logic              z_out,
  input logic              v_out,
  input logic              done,
  input logic              illegal
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(start) |-> done);

  assert_done_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    done |-> $past(start));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(start) |-> $stable({a_out, x_out, c_out, n_out, z_out, v_out}));

  assert_illegal_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  assert_sub_carry_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (done && $past(op_sub)) |-> (c_out == ($past(a_in & x_in) >= $past(imm))));

  assert_sub_keeps_a_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (done && $past(op_sub)) |-> (a_out == $past(a_in)));

  assert_v_carried_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    done |-> (v_out == $past(v_in)));

  assert_load_equal_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (done && $past(op_load)) |-> (a_out == x_out));

  assert_zero_tracks_a_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (done && ($past(op_merge) || $past(op_load))) |-> (z_out == (a_out == '0)));

endmodule

bind imm_op_unit imm_op_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .a_in     (a_in),
  .x_in     (x_in),
  .imm      (imm),
  .v_in     (v_in),
  .op_merge (op_merge),
  .op_load  (op_load),
  .op_sub   (op_sub),
  .a_out    (a_out),
  .x_out    (x_out),
  .c_out    (c_out),
  .n_out    (n_out),
  .z_out    (z_out),
  .v_out    (v_out),
  .done     (done),
  .illegal  (illegal)
);

// File: tb/sim_imm_op_unit.sv
module sim_imm_op_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] a_in = 8'h00;
  logic [7:0] x_in = 8'h00;
  logic [7:0] imm = 8'h00;
  logic       c_in = 1'b0, d_in = 1'b0, n_in = 1'b0, z_in = 1'b0, v_in = 1'b0;

  logic [7:0] a0, x0, a1, x1;
  logic       c0, n0, z0, v0, dn0, il0;
  logic       c1, n1, z1, v1, dn1, il1;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  imm_op_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .a_in(a_in), .x_in(x_in), .imm(imm),
    .c_in(c_in), .d_in(d_in), .n_in(n_in), .z_in(z_in), .v_in(v_in),
    .a_out(a0), .x_out(x0), .c_out(c0), .n_out(n0), .z_out(z0), .v_out(v0),
    .done(dn0), .illegal(il0)
  );

  imm_op_unit #(.PLAIN_LOAD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .a_in(a_in), .x_in(x_in), .imm(imm),
    .c_in(c_in), .d_in(d_in), .n_in(n_in), .z_in(z_in), .v_in(v_in),
    .a_out(a1), .x_out(x1), .c_out(c1), .n_out(n1), .z_out(z1), .v_out(v1),
    .done(dn1), .illegal(il1)
  );

  // Packed result: {a, x, c, n, z, v, done, illegal}
  function automatic logic [21:0] model(
    input logic [7:0] op, input logic [7:0] a, input logic [7:0] x,
    input logic [7:0] k, input logic c, input logic n, input logic z,
    input logic v, input bit plain
  );
    logic [7:0] ra, rx;
    logic rc, rn, rz, bad;
    int signed masked, delta;
    ra = a; rx = x; rc = c; rn = n; rz = z; bad = 1'b0;
    if (op == 8'h8B) begin
      ra = x & k & (8'hEE | a);
      rn = ra[7]; rz = (ra == 8'd0);
    end else if (op == 8'hAB) begin
      ra = plain ? (k & a) : (x & k & (8'hEE | a));
      rx = ra;
      rn = ra[7]; rz = (ra == 8'd0);
    end else if (op == 8'hCB) begin
      masked = int'(a & x);
      delta  = masked - int'(k);
      rx = delta[7:0];
      rc = (masked >= int'(k));
      rn = rx[7]; rz = (rx == 8'd0);
    end else begin
      bad = 1'b1;
    end
    return {ra, rx, rc, rn, rz, v, 1'b1, bad};
  endfunction

  function automatic string tag_of(input logic [7:0] op, input bit plain);
    if (op == 8'h8B) return "R3 R5";
    if (op == 8'hAB) return plain ? "R10" : "R4 R5";
    if (op == 8'hCB) return "R6 R7 R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [21:0] got, input logic [21:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one operation at a falling edge; sample at the next falling edge.
  task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] x,
                        input logic [7:0] k, input logic [4:0] fl);
    logic [21:0] e0, e1;
    @(negedge clk);
    opcode = op; a_in = a; x_in = x; imm = k;
    {c_in, d_in, n_in, z_in, v_in} = fl;
    start = 1'b1;
    e0 = model(op, a, x, k, fl[4], fl[2], fl[1], fl[0], 1'b0);
    e1 = model(op, a, x, k, fl[4], fl[2], fl[1], fl[0], 1'b1);
    @(negedge clk);
    start = 1'b0;
    check(tag_of(op, 1'b0), {a0, x0, c0, n0, z0, v0, dn0, il0}, e0);
    check(tag_of(op, 1'b1), {a1, x1, c1, n1, z1, v1, dn1, il1}, e1);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [21:0] snap;
    void'($urandom(32'd20250117));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {a0, x0, c0, n0, z0, v0, dn0, il0}, 22'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {a0, x0, c0, n0, z0, v0, dn0, il0}, 22'd0);

    // Directed corners
    run_op(8'h8B, 8'h11, 8'hFF, 8'hFF, 5'b00000); // merge uses constant plus A bits
    run_op(8'h8B, 8'h00, 8'h11, 8'hFF, 5'b00000); // zero result, z set
    run_op(8'hAB, 8'h01, 8'hFF, 8'hFF, 5'b10001); // load, C and V kept
    run_op(8'hCB, 8'h3C, 8'h0F, 8'h0C, 5'b00000); // equal: c=1, z=1
    run_op(8'hCB, 8'h0F, 8'h0F, 8'h10, 5'b00000); // borrow: wraps to FF, c=0
    // R6: decimal and carry-in must not change the subtraction
    run_op(8'hCB, 8'h99, 8'hFF, 8'h19, 5'b01000);
    run_op(8'hCB, 8'h99, 8'hFF, 8'h19, 5'b10000);
    run_op(8'hCB, 8'h99, 8'hFF, 8'h19, 5'b11001);
    run_op(8'hEB, 8'h55, 8'hAA, 8'h12, 5'b10111); // alias code is illegal (R9)

    // R2: no start -> done low, outputs held
    snap = {a0, x0, c0, n0, z0, v0, 1'b0, 1'b0};
    @(negedge clk);
    opcode = 8'h8B; a_in = 8'hFF; x_in = 8'hFF; imm = 8'hFF;
    @(negedge clk);
    check("R2", {a0, x0, c0, n0, z0, v0, dn0, il0}, snap);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] op;
      logic [1:0] pick;
      pick = 2'($urandom_range(0, 3));
      case (pick)
        2'd0: op = 8'h8B;
        2'd1: op = 8'hAB;
        2'd2: op = 8'hCB;
        default: op = 8'($urandom);
      endcase
      run_op(op, 8'($urandom), 8'($urandom), 8'($urandom), 5'($urandom));
      if ((i % 7) == 0) begin
        snap = {a0, x0, c0, n0, z0, v0, 1'b0, 1'b0};
        @(negedge clk);
        check("R2", {a0, x0, c0, n0, z0, v0, dn0, il0}, snap);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule